// File: doc/BRIEF.md
# Range-To-Mask-Word Encoder

This block turns a request to build a per-lane predicate into the compact form held by a mask register. The predicate is always a rectangle: a run of sublanes crossed with a run of lanes. The block emits it either as a 20-bit word carrying four inclusive bounds, or as a constant mask that is all on or all off.

Three request styles arrive on one port. A rectangle request gives inclusive first and last indices in both dimensions. A lane-only request gives a half-open lane range and covers every sublane. A sublane-only request gives a half-open sublane range and covers every lane. The block checks the bounds and rewrites both half-open styles to inclusive ends. It answers every request exactly one clock later, with either a valid result or an error.

Top module: `mask_word_encoder`

## Requirements
- R1: After reset, and until the first request is answered, rsp_valid and rsp_error are 0, rsp_kind is 00 and rsp_word is 0.
- R2: Each cycle with req_valid high produces exactly one of rsp_valid or rsp_error on the next cycle. A cycle without a request produces neither. rsp_valid and rsp_error are never high together.
- R3: A rectangle request (req_kind 00) whose bounds all pass is packed exactly as given, with no end adjustment, even when a start exceeds its end. Packed words use rsp_kind 00. The word layout is: first sublane in bits [2:0], first lane in bits [9:3], last sublane in bits [12:10], last lane in bits [19:13]. These positions do not depend on the LANES parameter.
- R4: A rectangle request covering sublanes 0..SUBLANES-1 and lanes 0..LANES-1 gives the constant all-on mask: rsp_kind 01 and rsp_word 0.
- R5: A rectangle request fails when any of its four bounds is not below its dimension's count (SUBLANES for sublane bounds, LANES for lane bounds).
- R6: A lane request (req_kind 01) for [lo, hi) gives a packed word with sublanes 0..SUBLANES-1, first lane lo and last lane hi-1.
- R7: A lane request with lo=0 and hi=LANES gives all-on (rsp_kind 01). A lane request with lo==hi gives all-off (rsp_kind 10). Both have rsp_word 0.
- R8: A sublane request (req_kind 10) for [lo, hi) gives a packed word with sublanes lo..hi-1 and lanes 0..LANES-1.
- R9: A sublane request with lo=0 and hi=SUBLANES gives all-on. A sublane request with lo==hi gives all-off.
- R10: A half-open request fails when hi exceeds its dimension's count or when lo exceeds hi.
- R11: A failed request, and any request with req_kind 11, raises rsp_error with rsp_valid low, rsp_kind 00 and rsp_word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Request style: 00 rectangle, 01 lane, 10 sublane, 11 reserved |
| req_sub_lo | input | 4 | Sublane start bound |
| req_sub_hi | input | 4 | Sublane end (inclusive for a rectangle, one past the end for a sublane request) |
| req_lane_lo | input | 8 | Lane start bound |
| req_lane_hi | input | 8 | Lane end (inclusive for a rectangle, one past the end for a lane request) |
| rsp_valid | output | 1 | Result valid |
| rsp_error | output | 1 | Request failed its bound check |
| rsp_kind | output | 2 | 00 packed word, 01 all-on, 10 all-off |
| rsp_word | output | 20 | Packed rectangle word |

## Verification
Because there is a single result register, a wrong value in it is visible at the ports one cycle after the request and is replaced by the next cycle's result. There is no hidden state that can carry a fault forward. An off-by-one in the half-open conversion shows up as a last lane or last sublane one step away from the expected value. A misrouted field shows up as bits landing in a neighbouring slice of the word. A lost bound check shows up as rsp_valid where rsp_error is expected. The scoreboard therefore checks every cycle, idle cycles included, against a model that assembles the word by concatenation.

// File: rtl/mwe_pkg.sv
package mwe_pkg;
  // Request styles accepted on req_kind
  typedef enum logic [1:0] {
    REQ_RECT = 2'b00,
    REQ_LANE = 2'b01,
    REQ_SUB  = 2'b10,
    REQ_RSVD = 2'b11
  } req_kind_e;

  // Result kinds on rsp_kind
  typedef enum logic [1:0] {
    RES_WORD    = 2'b00,
    RES_ALL_ON  = 2'b01,
    RES_ALL_OFF = 2'b10
  } res_kind_e;

  // Fixed wire format of the mask word
  localparam int SUB_FW  = 3;
  localparam int LANE_FW = 7;
  localparam int OFF_S0  = 0;
  localparam int OFF_L0  = 3;
  localparam int OFF_S1  = 10;
  localparam int OFF_L1  = 13;
  localparam int WORD_W  = OFF_L1 + LANE_FW;

  // Bound ports carry one extra bit so that "count" itself is expressible
  localparam int SUB_BW  = SUB_FW + 1;
  localparam int LANE_BW = LANE_FW + 1;

  typedef struct packed {
    logic [SUB_FW-1:0]  s_first;
    logic [LANE_FW-1:0] l_first;
    logic [SUB_FW-1:0]  s_last;
    logic [LANE_FW-1:0] l_last;
  } rect_t;
endpackage

// File: rtl/mwe_normalize.sv
module mwe_normalize
  import mwe_pkg::*;
#(
  parameter int SUBLANES = 8,
  parameter int LANES    = 128
) (
  input  logic [1:0]         kind,
  input  logic [SUB_BW-1:0]  sub_lo,
  input  logic [SUB_BW-1:0]  sub_hi,
  input  logic [LANE_BW-1:0] lane_lo,
  input  logic [LANE_BW-1:0] lane_hi,
  output logic               bad,
  output logic               full,
  output logic               empty,
  output rect_t              rect
);
  localparam logic [SUB_BW-1:0]  S_CNT  = SUB_BW'(SUBLANES);
  localparam logic [LANE_BW-1:0] L_CNT  = LANE_BW'(LANES);
  localparam logic [SUB_BW-1:0]  S_LAST = SUB_BW'(SUBLANES - 1);
  localparam logic [LANE_BW-1:0] L_LAST = LANE_BW'(LANES - 1);

  // Half-open ends turned into inclusive ends
  logic [SUB_BW-1:0]  sub_hi_m1;
  logic [LANE_BW-1:0] lane_hi_m1;
  assign sub_hi_m1  = sub_hi - 1'b1;
  assign lane_hi_m1 = lane_hi - 1'b1;

  always_comb begin
    bad   = 1'b0;
    full  = 1'b0;
    empty = 1'b0;
    rect  = '0;
    case (req_kind_e'(kind))
      REQ_RECT: begin
        bad  = (sub_lo >= S_CNT) || (sub_hi >= S_CNT) ||
               (lane_lo >= L_CNT) || (lane_hi >= L_CNT);
        full = (sub_lo == '0) && (sub_hi == S_LAST) &&
               (lane_lo == '0) && (lane_hi == L_LAST);
        rect.s_first = sub_lo[SUB_FW-1:0];
        rect.s_last  = sub_hi[SUB_FW-1:0];
        rect.l_first = lane_lo[LANE_FW-1:0];
        rect.l_last  = lane_hi[LANE_FW-1:0];
      end
      REQ_LANE: begin
        bad   = (lane_hi > L_CNT) || (lane_lo > lane_hi);
        full  = (lane_lo == '0) && (lane_hi == L_CNT);
        empty = (lane_lo == lane_hi);
        rect.s_first = '0;
        rect.s_last  = S_LAST[SUB_FW-1:0];
        rect.l_first = lane_lo[LANE_FW-1:0];
        rect.l_last  = lane_hi_m1[LANE_FW-1:0];
      end
      REQ_SUB: begin
        bad   = (sub_hi > S_CNT) || (sub_lo > sub_hi);
        full  = (sub_lo == '0) && (sub_hi == S_CNT);
        empty = (sub_lo == sub_hi);
        rect.s_first = sub_lo[SUB_FW-1:0];
        rect.s_last  = sub_hi_m1[SUB_FW-1:0];
        rect.l_first = '0;
        rect.l_last  = L_LAST[LANE_FW-1:0];
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/mwe_pack.sv
module mwe_pack
  import mwe_pkg::*;
(
  input  rect_t              rect,
  output logic [WORD_W-1:0]  word
);
  always_comb begin
    word = '0;
    word[OFF_S0 +: SUB_FW]  = rect.s_first;
    word[OFF_L0 +: LANE_FW] = rect.l_first;
    word[OFF_S1 +: SUB_FW]  = rect.s_last;
    word[OFF_L1 +: LANE_FW] = rect.l_last;
  end
endmodule

// File: rtl/mask_word_encoder.sv
module mask_word_encoder
  import mwe_pkg::*;
#(
  parameter int SUBLANES = 8,
  parameter int LANES    = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic [SUB_BW-1:0]   req_sub_lo,
  input  logic [SUB_BW-1:0]   req_sub_hi,
  input  logic [LANE_BW-1:0]  req_lane_lo,
  input  logic [LANE_BW-1:0]  req_lane_hi,
  output logic                rsp_valid,
  output logic                rsp_error,
  output logic [1:0]          rsp_kind,
  output logic [WORD_W-1:0]   rsp_word
);
  logic              n_bad, n_full, n_empty;
  rect_t             n_rect;
  logic [WORD_W-1:0] n_word;

  mwe_normalize #(.SUBLANES(SUBLANES), .LANES(LANES)) u_norm (
    .kind   (req_kind),
    .sub_lo (req_sub_lo),
    .sub_hi (req_sub_hi),
    .lane_lo(req_lane_lo),
    .lane_hi(req_lane_hi),
    .bad    (n_bad),
    .full   (n_full),
    .empty  (n_empty),
    .rect   (n_rect)
  );

  mwe_pack u_pack (
    .rect(n_rect),
    .word(n_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
      rsp_kind  <= RES_WORD;
      rsp_word  <= '0;
    end else begin
      rsp_valid <= req_valid && !n_bad;
      rsp_error <= req_valid && n_bad;
      rsp_kind  <= RES_WORD;
      rsp_word  <= '0;
      if (req_valid && !n_bad) begin
        if (n_full)       rsp_kind <= RES_ALL_ON;
        else if (n_empty) rsp_kind <= RES_ALL_OFF;
        else              rsp_word <= n_word;
      end
    end
  end

  p_one_of_r2: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_error));
  p_answer_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_valid || rsp_error));
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(rsp_valid || rsp_error));
  p_err_clear_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_error |-> (rsp_word == '0 && rsp_kind == RES_WORD));
  p_rsvd_fails_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == REQ_RSVD) |=> rsp_error);
  p_const_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind != RES_WORD) |-> rsp_word == '0);
  p_lane_rows_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == REQ_LANE) |=>
      (!rsp_valid || rsp_kind != RES_WORD ||
       (rsp_word[OFF_S0 +: SUB_FW] == '0 &&
        rsp_word[OFF_S1 +: SUB_FW] == SUB_FW'(SUBLANES - 1))));
endmodule

// File: tb/mask_word_encoder_test.sv
module mask_word_encoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [3:0]  req_sub_lo = '0, req_sub_hi = '0;
  logic [7:0]  req_lane_lo = '0, req_lane_hi = '0;
  logic        rsp_valid, rsp_error;
  logic [1:0]  rsp_kind;
  logic [19:0] rsp_word;

  int checks = 0;
  int errors = 0;
  bit armed  = 1'b0;
  bit done   = 1'b0;

  typedef struct {
    bit          v;
    bit          e;
    logic [1:0]  k;
    logic [19:0] w;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  mask_word_encoder uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_sub_lo(req_sub_lo), .req_sub_hi(req_sub_hi),
    .req_lane_lo(req_lane_lo), .req_lane_hi(req_lane_hi),
    .rsp_valid(rsp_valid), .rsp_error(rsp_error),
    .rsp_kind(rsp_kind), .rsp_word(rsp_word)
  );

  function automatic exp_t model(int kind, int slo, int shi, int llo, int lhi, string tag);
    exp_t x;
    x.v = 1'b1; x.e = 1'b0; x.k = 2'b00; x.w = '0; x.tag = tag;
    if (kind == 0) begin
      if (slo > 7 || shi > 7 || llo > 127 || lhi > 127) x.e = 1'b1;
      else if (slo == 0 && shi == 7 && llo == 0 && lhi == 127) x.k = 2'b01;
      else x.w = {7'(lhi), 3'(shi), 7'(llo), 3'(slo)};
    end else if (kind == 1) begin
      if (lhi > 128 || llo > lhi) x.e = 1'b1;
      else if (llo == 0 && lhi == 128) x.k = 2'b01;
      else if (llo == lhi) x.k = 2'b10;
      else x.w = {7'(lhi - 1), 3'd7, 7'(llo), 3'd0};
    end else if (kind == 2) begin
      if (shi > 8 || slo > shi) x.e = 1'b1;
      else if (slo == 0 && shi == 8) x.k = 2'b01;
      else if (slo == shi) x.k = 2'b10;
      else x.w = {7'd127, 3'(shi - 1), 7'd0, 3'(slo)};
    end else x.e = 1'b1;
    if (x.e) x.v = 1'b0;
    return x;
  endfunction

  task automatic send(int kind, int slo, int shi, int llo, int lhi, string tag);
    @(negedge clk);
    req_valid   = 1'b1;
    req_kind    = 2'(kind);
    req_sub_lo  = 4'(slo);
    req_sub_hi  = 4'(shi);
    req_lane_lo = 8'(llo);
    req_lane_hi = 8'(lhi);
    sb.push_back(model(kind, slo, shi, llo, lhi, tag));
  endtask

  task automatic idle(string tag);
    exp_t x;
    @(negedge clk);
    req_valid = 1'b0;
    req_kind  = 2'(3);
    x.v = 1'b0; x.e = 1'b0; x.k = 2'b00; x.w = '0; x.tag = tag;
    sb.push_back(x);
  endtask

  // Monitor: one scoreboard entry per clock once armed
  always @(posedge clk) begin
    #1;
    if (armed && sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      checks++;
      if (rsp_valid !== x.v || rsp_error !== x.e || rsp_kind !== x.k || rsp_word !== x.w) begin
        errors++;
        $display("FAIL %s: got v=%0b e=%0b k=%0d w=%05h, expected v=%0b e=%0b k=%0d w=%05h",
                 x.tag, rsp_valid, rsp_error, rsp_kind, rsp_word, x.v, x.e, x.k, x.w);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;  // R1 reset state
    if (rsp_valid !== 1'b0 || rsp_error !== 1'b0 || rsp_kind !== 2'b00 || rsp_word !== '0) begin
      errors++;
      $display("FAIL R1: got v=%0b e=%0b k=%0d w=%05h, expected all zero",
               rsp_valid, rsp_error, rsp_kind, rsp_word);
    end
    armed = 1'b1;

    send(0, 0, 3, 16, 63, "R3");      // 0x07ec80
    send(0, 5, 2, 100, 10, "R3");     // start beyond end packed raw
    send(0, 7, 7, 127, 127, "R3");
    send(0, 0, 7, 0, 127, "R4");
    send(0, 8, 7, 0, 0, "R5");
    send(0, 0, 8, 0, 0, "R5");
    send(0, 0, 0, 128, 3, "R5");
    send(0, 0, 0, 3, 128, "R5");
    idle("R2");
    send(1, 16, 0, 16, 64, "R6");
    send(1, 0, 0, 127, 128, "R6");
    send(1, 0, 0, 0, 128, "R7");
    send(1, 0, 0, 5, 5, "R7");
    send(1, 0, 0, 0, 129, "R10");
    send(1, 0, 0, 10, 9, "R10");
    idle("R2");
    idle("R2");
    send(2, 2, 5, 0, 0, "R8");
    send(2, 7, 8, 0, 0, "R8");
    send(2, 0, 8, 0, 0, "R9");
    send(2, 3, 3, 0, 0, "R9");
    send(2, 0, 9, 0, 0, "R10");
    send(2, 6, 2, 0, 0, "R10");
    send(3, 0, 3, 0, 3, "R11");
    send(0, 1, 9, 1, 1, "R11");
    // Small sweep of lane ranges
    for (int lo = 0; lo < 130; lo += 13) begin
      for (int hi = 0; hi < 131; hi += 29) send(1, 0, 0, lo, hi, "R6");
    end
    for (int lo = 0; lo < 9; lo++) begin
      for (int hi = 0; hi < 10; hi += 3) send(2, lo, hi, 0, 0, "R8");
    end
    idle("R2");
    while (sb.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule